// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the command-side guard of a serial flash device. While chip select is low it takes opcode and data bits, most significant bit first, on the rising edges of a serial clock. It keeps a small status register with a write-disable bit, a three-bit block-protect code and a write-enable latch. When select rises it decides whether the framed command may proceed. The commands it judges are a status write, a page program, a sector erase and a bulk erase. It never touches the memory array itself. It emits a one-cycle grant or deny strobe with a command kind, and the updated register contents appear on the status port.

The serial clock and select are sampled with the system clock, which must be several times faster than the serial clock. The write-protect pin is sampled on the cycle in which select rises. When the write-disable bit is set and that pin is low, the status register is locked in hardware. When the pin is high it can still be changed by software. The block-protect code fences a region at the top of a 32-sector array against program and erase. Bulk erase is refused while any part of the array is fenced.

Top module: `flash_guard`

## Requirements
- R1: After reset the status port reads 0x00, and grant, deny and op_kind are 0. Status layout: bit 7 write-disable, bits 4:2 block-protect code, bit 1 write-enable latch, the other bits 0.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch and produces no strobe.
- R3: A status-write frame (opcode 0x01 followed by one data byte, exactly 16 bits) with the latch set and write-disable 0 is granted whatever the level of wp_n. Data bit 7 loads write-disable and data bits 4:2 load the block-protect code.
- R4: A status write with the latch clear is denied and leaves the status unchanged.
- R5: With write-disable 1 and wp_n low, a status write is denied, the write-disable and block-protect bits keep their values, and the latch clears.
- R6: With write-disable 1 and wp_n high and the latch set, a status write is granted and can clear write-disable and change the block-protect code.
- R7: A frame whose bit count does not match its command exactly aborts: no strobe, and no status change, including the latch. For page program this means fewer than 40 bits or a count that is not a multiple of 8.
- R8: The latch is never loaded from the status data byte. It clears after every granted or denied command.
- R9: Page program (0x02, 24-bit address, at least one data byte) and sector erase (0xD8, 24-bit address, exactly 32 bits) are denied when the latch is clear or the target is fenced. Otherwise they are granted.
- R10: Block-protect code n from 1 to 6 fences the top 1/2^(7-n) of a 2 MiB space. The space holds 32 sectors of 64 KiB and is addressed by the low 21 address bits. Code 7 fences everything and code 0 fences nothing. A sector erase is fenced if any byte of its sector is fenced. A page program is fenced if its start address is fenced.
- R11: Bulk erase (0xC7, exactly 8 bits) with the latch set is denied whenever the block-protect code is nonzero and granted when it is zero.
- R12: A decision appears exactly one system clock after select rises, as a one-cycle strobe with at most one of grant and deny high. op_kind is 1 for status write, 2 for page program, 3 for sector erase, 4 for bulk erase, and 0 when there is no strobe. The status port changes only in that cycle. The serial data output enable is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, bit taken on its rising edge |
| sdi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| so_oe | output | 1 | Serial output enable, held 0 (line stays high impedance) |
| status | output | 8 | Status register contents |
| grant | output | 1 | One-cycle strobe: command allowed |
| deny | output | 1 | One-cycle strobe: command refused |
| op_kind | output | 3 | Kind of the command judged in the strobe cycle |

## Verification
The embedded assertions watch, on every cycle, that grant and deny never coincide and last one cycle. They check that the status register moves only in the cycle after select rises and that every strobe leaves the latch clear. They also check that any grant was preceded by a set latch, that no status write gets through while the hardware lock is active, and that no bulk erase is granted while a region is fenced. The bench's scenarios are needed to show the actual region boundaries for each protect code and the sector-overlap rule. They also cover the abort of frames with wrong bit counts and the way the data byte maps onto the register fields.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int         MEM_AW  = 21,
  parameter int         SECT_AW = 16,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRSR = 8'h01,
  parameter logic [7:0] OP_PROG = 8'h02,
  parameter logic [7:0] OP_SECT = 8'hD8,
  parameter logic [7:0] OP_BULK = 8'hC7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic       wp_n,
  output logic       so_oe,
  output logic [7:0] status,
  output logic       grant,
  output logic       deny,
  output logic [2:0] op_kind
);

  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_STAT = 3'd1;
  localparam logic [2:0] K_PROG = 3'd2;
  localparam logic [2:0] K_SECT = 3'd3;
  localparam logic [2:0] K_BULK = 3'd4;

  logic              sck_q, cs_q;
  logic [2:0]        bitc, nby;
  logic [6:0]        shreg;
  logic [7:0]        opc;
  logic [MEM_AW-1:0] addr;
  logic              dat_wd;
  logic [2:0]        dat_bp;
  logic              wd, wel;
  logic [2:0]        bp;

  wire       sck_rise  = sck & ~sck_q & ~cs_n;
  wire       cs_rise   = cs_n & ~cs_q;
  wire [7:0] byte_in   = {shreg, sdi};
  wire       byte_done = sck_rise && (bitc == 3'd7);

  assign so_oe  = 1'b0;
  assign status = {wd, 2'b00, bp, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      bitc   <= '0;
      nby    <= '0;
      shreg  <= '0;
      opc    <= '0;
      addr   <= '0;
      dat_wd <= 1'b0;
      dat_bp <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bitc <= '0;
        nby  <= '0;
      end else if (sck_rise) begin
        bitc  <= bitc + 3'd1;
        shreg <= byte_in[6:0];
        if (byte_done) begin
          if (nby != 3'd7) nby <= nby + 3'd1;
          if (nby == 3'd0) opc <= byte_in;
          if (nby == 3'd1) begin
            dat_wd <= byte_in[7];
            dat_bp <= byte_in[4:2];
          end
          if (nby >= 3'd1 && nby <= 3'd3) addr <= {addr[MEM_AW-9:0], byte_in};
        end
      end
    end
  end

  function automatic logic fenced(input logic [2:0] code, input logic [MEM_AW-1:0] a);
    int k;
    logic h;
    k = 7 - int'(code);
    h = (code != 3'd0);
    if (code != 3'd0 && code != 3'd7)
      for (int i = 0; i < 7; i++)
        if (i < k && !a[MEM_AW-1-i]) h = 1'b0;
    return h;
  endfunction

  wire whole   = cs_rise && (bitc == 3'd0);
  wire is_we   = whole && opc == OP_WREN && nby == 3'd1;
  wire is_sr   = whole && opc == OP_WRSR && nby == 3'd2;
  wire is_pp   = whole && opc == OP_PROG && nby >= 3'd5;
  wire is_se   = whole && opc == OP_SECT && nby == 3'd4;
  wire is_be   = whole && opc == OP_BULK && nby == 3'd1;
  wire hw_lock = wd & ~wp_n;

  wire [MEM_AW-1:0] sect_top = {addr[MEM_AW-1:SECT_AW], {SECT_AW{1'b1}}};

  logic       g, d;
  logic [2:0] k;

  always_comb begin
    g = 1'b0;
    d = 1'b0;
    k = K_NONE;
    if (is_sr) begin
      k = K_STAT;
      if (!wel || hw_lock) d = 1'b1; else g = 1'b1;
    end else if (is_pp) begin
      k = K_PROG;
      if (!wel || fenced(bp, addr)) d = 1'b1; else g = 1'b1;
    end else if (is_se) begin
      k = K_SECT;
      if (!wel || fenced(bp, sect_top)) d = 1'b1; else g = 1'b1;
    end else if (is_be) begin
      k = K_BULK;
      if (!wel || bp != 3'd0) d = 1'b1; else g = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant   <= 1'b0;
      deny    <= 1'b0;
      op_kind <= K_NONE;
      wd      <= 1'b0;
      bp      <= '0;
      wel     <= 1'b0;
    end else begin
      grant   <= g;
      deny    <= d;
      op_kind <= k;
      if (is_we) wel <= 1'b1;
      if (g || d) wel <= 1'b0;
      if (g && is_sr) begin
        wd <= dat_wd;
        bp <= dat_bp;
      end
    end
  end

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));
  assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |=> !(grant || deny));
  assert_status_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(cs_n) && !$past(cs_n, 2)) |-> $stable(status));
  assert_latch_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> !status[1]);
  assert_grant_needs_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(status[1]));
  assert_hw_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op_kind == K_STAT) |-> (!$past(status[7]) || $past(wp_n)));
  assert_bulk_fence_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op_kind == K_BULK) |-> $past(status[4:2]) == 3'd0);

endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wp_n = 1'b1;
  logic       so_oe, grant, deny;
  logic [7:0] status;
  logic [2:0] op_kind;

  flash_guard u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .wp_n(wp_n),
                  .so_oe(so_oe), .status(status), .grant(grant), .deny(deny), .op_kind(op_kind));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, fails = 0;
  bit    m_wd = 0, m_wel = 0;
  bit [2:0] m_bp = 0;
  bit    eg = 0, ed = 0;
  bit [2:0] eop = 0;
  bit    mon_on = 0;
  bit    got_g, got_d;
  string tag = "R1";

  function automatic logic [7:0] m_status();
    return {m_wd, 2'b00, m_bp, m_wel, 1'b0};
  endfunction

  always @(negedge clk) if (mon_on) begin
    checks++;
    if ({status, grant, deny, op_kind, so_oe} !== {m_status(), eg, ed, eop, 1'b0}) begin
      fails++;
      $display("FAIL R12 (%s) t=%0t status=%h g=%b d=%b op=%0d oe=%b expected status=%h g=%b d=%b op=%0d oe=0",
               tag, $time, status, grant, deny, op_kind, so_oe, m_status(), eg, ed, eop);
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic bit prot(input int code, input int a, input bit sect);
    int start, last;
    if (code == 0) return 0;
    start = (1 << 21) - ((1 << 21) >> (7 - code));
    last  = a & 32'h1FFFFF;
    if (sect) last = last | 32'hFFFF;
    return last >= start;
  endfunction

  task automatic model(input int nbits, input logic [47:0] v, input bit wp);
    int nb, a;
    logic [7:0] op, dat;
    if (nbits % 8 != 0 || nbits < 8) return;
    nb = nbits / 8;
    op = v[nbits-1 -: 8];
    case (op)
      8'h06: if (nb == 1) m_wel = 1;
      8'h01: if (nb == 2) begin
        dat = v[7:0];
        eop = 1;
        if (!m_wel || (m_wd && !wp)) ed = 1;
        else begin eg = 1; m_wd = dat[7]; m_bp = dat[4:2]; end
        m_wel = 0;
      end
      8'h02: if (nb >= 5) begin
        a = int'(v[nbits-9 -: 24]);
        eop = 2;
        if (!m_wel || prot(m_bp, a, 0)) ed = 1; else eg = 1;
        m_wel = 0;
      end
      8'hD8: if (nb == 4) begin
        a = int'(v[23:0]);
        eop = 3;
        if (!m_wel || prot(m_bp, a, 1)) ed = 1; else eg = 1;
        m_wel = 0;
      end
      8'hC7: if (nb == 1) begin
        eop = 4;
        if (!m_wel || m_bp != 0) ed = 1; else eg = 1;
        m_wel = 0;
      end
      default: ;
    endcase
  endtask

  task automatic frame(input int nbits, input logic [47:0] v, input bit wp);
    wp_n = wp;
    @(negedge clk) cs_n = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk) begin sdi = v[i]; sck = 1'b0; end
      @(negedge clk);
      @(negedge clk) sck = 1'b1;
      @(negedge clk);
    end
    @(negedge clk) sck = 1'b0;
    @(negedge clk);
    @(negedge clk) cs_n = 1'b1;
    @(posedge clk);
    #1 model(nbits, v, wp);
    @(negedge clk) begin got_g = grant; got_d = deny; end
    @(posedge clk);
    #1 begin eg = 0; ed = 0; eop = 0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic wren();
    frame(8, 48'h06, 1'b1);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", status, 8'h00);
    check("R1 strobes", {grant, deny, op_kind}, 5'd0);
    mon_on = 1;

    tag = "R4";
    frame(16, {8'h01, 8'h9C}, 1'b1);
    check("R4 deny", got_d, 1); check("R4 status", status, 8'h00);

    tag = "R7";
    frame(7, 48'h03, 1'b1);
    check("R7 short enable", status, 8'h00);

    tag = "R2";
    wren();
    check("R2 latch", status, 8'h02);

    tag = "R7";
    frame(17, {8'h01, 8'h9F, 1'b0}, 1'b1);
    check("R7 long status write", {got_g, got_d, status}, {2'b00, 8'h02});

    tag = "R3";
    frame(16, {8'h01, 8'h9F}, 1'b0);
    check("R3 grant pin low", got_g, 1);
    check("R8 data ignored for latch", status, 8'h9C);

    tag = "R5";
    wren();
    frame(16, {8'h01, 8'h00}, 1'b0);
    check("R5 hw lock deny", got_d, 1); check("R5 status kept", status, 8'h9C);

    tag = "R6";
    wren();
    frame(16, {8'h01, 8'h08}, 1'b1);
    check("R6 sw mode grant", got_g, 1); check("R6 status", status, 8'h08);

    tag = "R10";
    wren();
    frame(40, {8'h02, 24'h1F0000, 8'hAA}, 1'b1);
    check("R10 code2 top sector deny", got_d, 1);
    wren();
    frame(40, {8'h02, 24'h1EFF00, 8'hAA}, 1'b1);
    check("R10 code2 below grant", got_g, 1);

    tag = "R9";
    frame(40, {8'h02, 24'h000000, 8'h55}, 1'b1);
    check("R9 no latch deny", got_d, 1);

    tag = "R10";
    wren(); frame(16, {8'h01, 8'h04}, 1'b1);
    check("R10 code1 set", status, 8'h04);
    wren(); frame(32, {8'hD8, 24'h1F0000}, 1'b1);
    check("R10 sector overlap deny", got_d, 1);
    wren(); frame(32, {8'hD8, 24'h1E1234}, 1'b1);
    check("R9 sector grant", got_g, 1);
    wren(); frame(40, {8'h02, 24'h1F7F00, 8'h00}, 1'b1);
    check("R10 code1 half sector grant", got_g, 1);

    tag = "R11";
    wren(); frame(8, 48'hC7, 1'b1);
    check("R11 bulk fenced deny", got_d, 1);
    wren(); frame(16, {8'h01, 8'h00}, 1'b1);
    wren(); frame(8, 48'hC7, 1'b1);
    check("R11 bulk grant", got_g, 1); check("R11 status", status, 8'h00);

    tag = "R10";
    wren(); frame(16, {8'h01, 8'h1C}, 1'b1);
    wren(); frame(40, {8'h02, 24'h000000, 8'h11}, 1'b1);
    check("R10 code7 all fenced", got_d, 1);

    tag = "R7";
    wren(); frame(36, {8'h02, 24'h000100, 4'h3}, 1'b1);
    check("R7 odd program length", {got_g, got_d, status}, {2'b00, 8'h1E});

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule